// File: doc/BRIEF.md
# Path Overhead Transmit Byte Selector

This block builds the three path overhead bytes that carry parity (B3), the signal label (C2) and path status (G1) in the transmit direction of a SONET/SDH path. Software programs three byte-wide registers through a small write port. Per-byte control bits then choose where each transmitted byte comes from: the software register, a byte supplied on the external overhead interface, or internal logic. The B3 parity itself is computed elsewhere and arrives as an input. This block can corrupt it bit by bit through an error mask, or replace it entirely with the register contents for testing.

For C2 and G1 there are three source modes. In register mode the software byte is sent. In capture mode the external byte is sent and is also stored in the register. In pass mode the external byte is sent and the register keeps the value software wrote. In register mode, the G1 remote-defect bit and the four-bit far-end error count can each be taken from internal inputs in place of the register fields. Register bit 7 is always the first bit sent.

A two-state sequencer paces the outputs. In state SEQ_WAIT it waits for the frame strobe. Seeing the strobe moves it to SEQ_LOAD. In SEQ_LOAD the output bytes and any captures are registered, and the sequencer returns unconditionally to SEQ_WAIT. Outside SEQ_LOAD the outputs hold.

Top module: `poh_tx_sel`

## Requirements
- R1: While reset (rst_n low) is asserted, and after it is released, the three output bytes read 00h until the first load step. All three registers also start at 00h.
- R2: A high frame_stb sampled at a clock edge in SEQ_WAIT moves the sequencer to SEQ_LOAD. The output bytes change only at the following edge, the load edge. Otherwise they hold their value.
- R3: With test_b3 = 0, b3_out at the load edge equals b3_calc XOR the B3 mask register.
- R4: A nonzero mask keeps corrupting every frame until software writes 00h to the mask register. After that write, b3_out equals b3_calc.
- R5: With test_b3 = 1, b3_out equals the mask register contents, and b3_calc is ignored.
- R6: With ext_c2 = 0, c2_out equals the C2 register.
- R7: With ext_c2 = 1 and ram_cap = 1, c2_out equals ext_c2_byte, and that byte is stored in the C2 register at the load edge.
- R8: With ext_c2 = 1 and ram_cap = 0, c2_out equals ext_c2_byte, and the C2 register keeps its software-written value.
- R9: G1 uses the same three modes, selected by ext_g1 and ram_cap, with ext_g1_byte as the external byte.
- R10: With ext_g1 = 0, the G1 byte is laid out as follows. Bits 7..4 are the far-end error count, taken from febe_cnt when febe_en = 1 and from the register otherwise. Bit 3 is the remote-defect bit, taken from rdi_in when rdi_en = 1 and from the register otherwise. Bits 2..0 always come from the register.
- R11: With ext_g1 = 1, rdi_en and febe_en have no effect, and g1_out equals ext_g1_byte.
- R12: If a software write and a capture target the same register at the load edge, the capture value is stored.
- R13: Write addresses are decoded as 0 = B3 mask, 1 = C2, 2 = G1. A write to address 3 changes nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| frame_stb | input | 1 | One pulse per frame; starts a load step |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 2 | Register select (0 mask, 1 C2, 2 G1) |
| wr_data | input | 8 | Register write data |
| test_b3 | input | 1 | 1: send mask register as B3 |
| ext_c2 | input | 1 | 1: C2 from external byte |
| ext_g1 | input | 1 | 1: G1 from external byte |
| ram_cap | input | 1 | 1: copy external bytes into registers |
| rdi_en | input | 1 | Take G1 remote-defect bit from rdi_in |
| febe_en | input | 1 | Take G1 error count from febe_cnt |
| b3_calc | input | 8 | Precomputed path parity byte |
| ext_c2_byte | input | 8 | External C2 byte |
| ext_g1_byte | input | 8 | External G1 byte |
| rdi_in | input | 1 | Internal remote-defect state |
| febe_cnt | input | 4 | Internal far-end error count |
| b3_out | output | 8 | Transmitted B3 |
| c2_out | output | 8 | Transmitted C2 |
| g1_out | output | 8 | Transmitted G1 |

## Verification
The bench targets the difference between capture mode and pass mode. It returns to register mode after each, which exposes the stored value: a design that ignored ram_cap would either lose the captured byte or overwrite the software value. A write placed exactly on the load edge while capture is active shows whether the design lets software win, which would store the wrong byte. The G1 field cases set each override in isolation and together, and then with the external source active. A design that shifted the remote-defect bit, or leaked the overrides into external mode, would send a wrong G1. Mask persistence, outputs held with no strobe, and the unused write address complete the set.

// File: rtl/poh_tx_pkg.sv
package poh_tx_pkg;

    typedef enum logic [1:0] {
        ADDR_B3MASK = 2'd0,
        ADDR_C2     = 2'd1,
        ADDR_G1     = 2'd2,
        ADDR_SPARE  = 2'd3
    } poh_addr_e;

    typedef enum logic {
        SEQ_WAIT = 1'b0,
        SEQ_LOAD = 1'b1
    } seq_state_e;

    typedef enum logic [1:0] {
        SRC_REG         = 2'd0,
        SRC_EXT_CAPTURE = 2'd1,
        SRC_EXT_PASS    = 2'd2
    } src_mode_e;

    function automatic src_mode_e pick_src(input logic ext_sel, input logic ram_cap);
        if (!ext_sel)     return SRC_REG;
        else if (ram_cap) return SRC_EXT_CAPTURE;
        else              return SRC_EXT_PASS;
    endfunction

endpackage

// File: rtl/poh_seq.sv
module poh_seq
    import poh_tx_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic frame_stb,
    output logic load
);

    seq_state_e state_q, state_d;

    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= SEQ_WAIT;
        else        state_q <= state_d;
    end

    always_comb begin
        state_d = state_q;
        load    = 1'b0;
        unique case (state_q)
            SEQ_WAIT: begin
                if (frame_stb) state_d = SEQ_LOAD;
            end
            SEQ_LOAD: begin
                load    = 1'b1;
                state_d = SEQ_WAIT;
            end
            default: state_d = SEQ_WAIT;
        endcase
    end

    // R2: the load step lasts one cycle
    assert_load_single_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == SEQ_LOAD) |=> (state_q == SEQ_WAIT));

    // R2: a strobe seen while waiting leads to a load step
    assert_strobe_loads_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == SEQ_WAIT && frame_stb) |=> load);

endmodule

// File: rtl/poh_ovh_reg.sv
module poh_ovh_reg #(
    parameter int unsigned W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         wr_hit,
    input  logic [W-1:0] wr_data,
    input  logic         cap_en,
    input  logic [W-1:0] cap_data,
    output logic [W-1:0] q
);

    always_ff @(posedge clk) begin
        if (!rst_n)      q <= '0;
        else if (cap_en) q <= cap_data;
        else if (wr_hit) q <= wr_data;
    end

    // R12: a capture overrides a simultaneous write
    assert_capture_wins_R12: assert property (@(posedge clk) disable iff (!rst_n)
        (cap_en && wr_hit) |=> (q == $past(cap_data)));

endmodule

// File: rtl/poh_b3_stage.sv
module poh_b3_stage #(
    parameter int unsigned W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         load,
    input  logic         test_mode,
    input  logic [W-1:0] calc,
    input  logic [W-1:0] mask,
    output logic [W-1:0] b3_q
);

    logic [W-1:0] b3_d;

    always_comb begin
        if (test_mode) b3_d = mask;
        else           b3_d = calc ^ mask;
    end

    always_ff @(posedge clk) begin
        if (!rst_n)    b3_q <= '0;
        else if (load) b3_q <= b3_d;
    end

    // R3: each set mask bit flips exactly that parity bit
    assert_b3_inject_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (load && !test_mode) |=> ((b3_q ^ $past(calc)) == $past(mask)));

    // R5: in test mode the parity input does not reach the output
    assert_b3_override_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (load && test_mode) |=> (b3_q == $past(mask)));

endmodule

// File: rtl/poh_label_sel.sv
module poh_label_sel
    import poh_tx_pkg::*;
#(
    parameter int unsigned W        = 8,
    parameter int unsigned FEBE_W   = 4,
    parameter bit          HAS_FLDS = 1'b0
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load,
    input  src_mode_e         mode,
    input  logic              wr_hit,
    input  logic [W-1:0]      wr_data,
    input  logic [W-1:0]      ext_byte,
    input  logic              rdi_en,
    input  logic              febe_en,
    input  logic              rdi_in,
    input  logic [FEBE_W-1:0] febe_in,
    output logic [W-1:0]      byte_q
);

    localparam int unsigned RDI_POS  = W - 1 - FEBE_W;
    localparam int unsigned FEBE_LSB = W - FEBE_W;

    logic [W-1:0] reg_q;
    logic [W-1:0] local_byte;
    logic [W-1:0] byte_d;
    logic         cap_en;

    assign cap_en = load && (mode == SRC_EXT_CAPTURE);

    poh_ovh_reg #(.W(W)) u_store (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr_hit   (wr_hit),
        .wr_data  (wr_data),
        .cap_en   (cap_en),
        .cap_data (ext_byte),
        .q        (reg_q)
    );

    generate
        if (HAS_FLDS) begin : g_fields
            always_comb begin
                local_byte = reg_q;
                if (febe_en) local_byte[W-1:FEBE_LSB] = febe_in;
                if (rdi_en)  local_byte[RDI_POS]      = rdi_in;
            end

            // R10: internal remote-defect state reaches its bit in register mode
            assert_rdi_field_R10: assert property (@(posedge clk) disable iff (!rst_n)
                (load && mode == SRC_REG && rdi_en) |=> (byte_q[RDI_POS] == $past(rdi_in)));

            // R10: unassigned bits always follow the register
            assert_spare_bits_R10: assert property (@(posedge clk) disable iff (!rst_n)
                (load && mode == SRC_REG) |=> (byte_q[RDI_POS-1:0] == $past(reg_q[RDI_POS-1:0])));
        end else begin : g_plain
            logic unused_fields;
            assign unused_fields = ^{rdi_en, febe_en, rdi_in, febe_in};
            assign local_byte = reg_q;
        end
    endgenerate

    always_comb begin
        unique case (mode)
            SRC_REG:         byte_d = local_byte;
            SRC_EXT_CAPTURE: byte_d = ext_byte;
            SRC_EXT_PASS:    byte_d = ext_byte;
            default:         byte_d = local_byte;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n)    byte_q <= '0;
        else if (load) byte_q <= byte_d;
    end

    // R7: capture mode stores the external byte
    assert_capture_store_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (load && mode == SRC_EXT_CAPTURE) |=> (reg_q == $past(ext_byte)));

    // R8: pass mode leaves the register alone
    assert_pass_keeps_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (load && mode == SRC_EXT_PASS && !wr_hit) |=> $stable(reg_q));

    // R11: external modes send the external byte untouched
    assert_ext_send_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (load && mode != SRC_REG) |=> (byte_q == $past(ext_byte)));

endmodule

// File: rtl/poh_tx_sel.sv
module poh_tx_sel
    import poh_tx_pkg::*;
#(
    parameter int unsigned BYTE_W = 8,
    parameter int unsigned FEBE_W = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              frame_stb,
    input  logic              wr_en,
    input  logic [1:0]        wr_addr,
    input  logic [BYTE_W-1:0] wr_data,
    input  logic              test_b3,
    input  logic              ext_c2,
    input  logic              ext_g1,
    input  logic              ram_cap,
    input  logic              rdi_en,
    input  logic              febe_en,
    input  logic [BYTE_W-1:0] b3_calc,
    input  logic [BYTE_W-1:0] ext_c2_byte,
    input  logic [BYTE_W-1:0] ext_g1_byte,
    input  logic              rdi_in,
    input  logic [FEBE_W-1:0] febe_cnt,
    output logic [BYTE_W-1:0] b3_out,
    output logic [BYTE_W-1:0] c2_out,
    output logic [BYTE_W-1:0] g1_out
);

    logic              load;
    logic              hit_mask, hit_c2, hit_g1;
    logic [BYTE_W-1:0] mask_q;
    src_mode_e         c2_mode, g1_mode;
    poh_addr_e         addr;

    assign addr     = poh_addr_e'(wr_addr);
    assign hit_mask = wr_en && (addr == ADDR_B3MASK);
    assign hit_c2   = wr_en && (addr == ADDR_C2);
    assign hit_g1   = wr_en && (addr == ADDR_G1);
    assign c2_mode  = pick_src(ext_c2, ram_cap);
    assign g1_mode  = pick_src(ext_g1, ram_cap);

    poh_seq u_seq (
        .clk       (clk),
        .rst_n     (rst_n),
        .frame_stb (frame_stb),
        .load      (load)
    );

    poh_ovh_reg #(.W(BYTE_W)) u_mask (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr_hit   (hit_mask),
        .wr_data  (wr_data),
        .cap_en   (1'b0),
        .cap_data ('0),
        .q        (mask_q)
    );

    poh_b3_stage #(.W(BYTE_W)) u_b3 (
        .clk       (clk),
        .rst_n     (rst_n),
        .load      (load),
        .test_mode (test_b3),
        .calc      (b3_calc),
        .mask      (mask_q),
        .b3_q      (b3_out)
    );

    poh_label_sel #(.W(BYTE_W), .FEBE_W(FEBE_W), .HAS_FLDS(1'b0)) u_c2 (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (load),
        .mode     (c2_mode),
        .wr_hit   (hit_c2),
        .wr_data  (wr_data),
        .ext_byte (ext_c2_byte),
        .rdi_en   (1'b0),
        .febe_en  (1'b0),
        .rdi_in   (1'b0),
        .febe_in  ('0),
        .byte_q   (c2_out)
    );

    poh_label_sel #(.W(BYTE_W), .FEBE_W(FEBE_W), .HAS_FLDS(1'b1)) u_g1 (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (load),
        .mode     (g1_mode),
        .wr_hit   (hit_g1),
        .wr_data  (wr_data),
        .ext_byte (ext_g1_byte),
        .rdi_en   (rdi_en),
        .febe_en  (febe_en),
        .rdi_in   (rdi_in),
        .febe_in  (febe_cnt),
        .byte_q   (g1_out)
    );

    // R2: outputs hold between load steps
    assert_hold_outputs_R2: assert property (@(posedge clk) disable iff (!rst_n)
        !load |=> ($stable(b3_out) && $stable(c2_out) && $stable(g1_out)));

    // R13: spare address never touches the mask
    assert_spare_addr_R13: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wr_addr == 2'd3) |=> $stable(mask_q));

endmodule

// File: tb/poh_tx_sel_test.sv
module poh_tx_sel_test;

    localparam int CLK_PERIOD = 10;

    typedef struct packed {
        logic       test, xc2, xg1, ram, ren, fen;
        logic [7:0] calc, ec2, eg1;
        logic       rdi;
        logic [3:0] febe;
        logic [7:0] exp_b3, exp_c2, exp_g1;
    } vec_t;

    // registers preset: mask 81h, C2 13h, G1 A5h (FEBE 1010, RDI 0, spare 101)
    localparam vec_t TBL [8] = '{
        '{1'b0,1'b0,1'b0,1'b0,1'b0,1'b0, 8'h3C,8'h00,8'h00, 1'b0,4'h0, 8'hBD,8'h13,8'hA5},
        '{1'b1,1'b0,1'b0,1'b0,1'b0,1'b0, 8'h3C,8'h00,8'h00, 1'b0,4'h0, 8'h81,8'h13,8'hA5},
        '{1'b0,1'b1,1'b0,1'b0,1'b0,1'b0, 8'h00,8'h55,8'h00, 1'b0,4'h0, 8'h81,8'h55,8'hA5},
        '{1'b0,1'b0,1'b1,1'b0,1'b0,1'b0, 8'hFF,8'h00,8'h6E, 1'b0,4'h0, 8'h7E,8'h13,8'h6E},
        '{1'b0,1'b0,1'b0,1'b0,1'b1,1'b0, 8'h81,8'h00,8'h00, 1'b1,4'h0, 8'h00,8'h13,8'hAD},
        '{1'b0,1'b0,1'b0,1'b0,1'b0,1'b1, 8'h00,8'h00,8'h00, 1'b1,4'h3, 8'h81,8'h13,8'h35},
        '{1'b0,1'b0,1'b0,1'b0,1'b1,1'b1, 8'h00,8'h00,8'h00, 1'b1,4'hF, 8'h81,8'h13,8'hFD},
        '{1'b0,1'b0,1'b1,1'b0,1'b1,1'b1, 8'h00,8'h00,8'h12, 1'b1,4'hF, 8'h81,8'h13,8'h12}
    };

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       frame_stb = 1'b0;
    logic       wr_en = 1'b0;
    logic [1:0] wr_addr = 2'd0;
    logic [7:0] wr_data = 8'h00;
    logic       test_b3 = 1'b0, ext_c2 = 1'b0, ext_g1 = 1'b0, ram_cap = 1'b0;
    logic       rdi_en = 1'b0, febe_en = 1'b0, rdi_in = 1'b0;
    logic [7:0] b3_calc = 8'h00, ext_c2_byte = 8'h00, ext_g1_byte = 8'h00;
    logic [3:0] febe_cnt = 4'h0;
    logic [7:0] b3_out, c2_out, g1_out;

    int checks = 0;
    int errors = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    poh_tx_sel uut (
        .clk(clk), .rst_n(rst_n), .frame_stb(frame_stb),
        .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
        .test_b3(test_b3), .ext_c2(ext_c2), .ext_g1(ext_g1), .ram_cap(ram_cap),
        .rdi_en(rdi_en), .febe_en(febe_en), .b3_calc(b3_calc),
        .ext_c2_byte(ext_c2_byte), .ext_g1_byte(ext_g1_byte),
        .rdi_in(rdi_in), .febe_cnt(febe_cnt),
        .b3_out(b3_out), .c2_out(c2_out), .g1_out(g1_out)
    );

    task automatic check8(input string req, input string what,
                          input logic [7:0] act, input logic [7:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s actual %02h expected %02h", req, what, act, exp);
        end
    endtask

    task automatic write_reg(input logic [1:0] a, input logic [7:0] d);
        @(negedge clk);
        wr_en = 1'b1; wr_addr = a; wr_data = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    // strobe, load edge, then sample at the following falling edge
    task automatic run_frame();
        @(negedge clk);
        frame_stb = 1'b1;
        @(negedge clk);
        frame_stb = 1'b0;
        @(negedge clk);
    endtask

    task automatic set_ctrl(input logic t, input logic c, input logic g, input logic r,
                            input logic re, input logic fe);
        test_b3 = t; ext_c2 = c; ext_g1 = g; ram_cap = r; rdi_en = re; febe_en = fe;
    endtask

    initial begin
        #(CLK_PERIOD * 50000);
        errors++;
        $display("FAIL watchdog expired");
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        // R1: reset state
        check8("R1", "b3 in reset", b3_out, 8'h00);
        rst_n = 1'b1;
        @(negedge clk);
        check8("R1", "c2 after reset", c2_out, 8'h00);
        check8("R1", "g1 after reset", g1_out, 8'h00);
        run_frame();
        check8("R1", "registers zero b3", b3_out, 8'h00);
        check8("R1", "registers zero g1", g1_out, 8'h00);

        write_reg(2'd0, 8'h81);
        write_reg(2'd1, 8'h13);
        write_reg(2'd2, 8'hA5);

        // table walk: R3 R5 R6 R8 R9 R10 R11
        foreach (TBL[i]) begin
            set_ctrl(TBL[i].test, TBL[i].xc2, TBL[i].xg1, TBL[i].ram, TBL[i].ren, TBL[i].fen);
            b3_calc = TBL[i].calc; ext_c2_byte = TBL[i].ec2; ext_g1_byte = TBL[i].eg1;
            rdi_in = TBL[i].rdi; febe_cnt = TBL[i].febe;
            run_frame();
            check8("R3/R5 table", "b3", b3_out, TBL[i].exp_b3);
            check8("R6/R8 table", "c2", c2_out, TBL[i].exp_c2);
            check8("R10/R11 table", "g1", g1_out, TBL[i].exp_g1);
        end

        // R2: no strobe, inputs change, outputs hold
        set_ctrl(1'b1, 1'b1, 1'b1, 1'b0, 1'b0, 1'b0);
        b3_calc = 8'hF0; ext_c2_byte = 8'hEE; ext_g1_byte = 8'hDD;
        repeat (4) @(negedge clk);
        check8("R2", "b3 held", b3_out, 8'h81);
        check8("R2", "c2 held", c2_out, 8'h13);

        // R8: pass mode left register at 13h
        set_ctrl(1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0);
        b3_calc = 8'h00;
        run_frame();
        check8("R8", "c2 register kept", c2_out, 8'h13);
        check8("R9", "g1 register kept", g1_out, 8'hA5);

        // R7 and R9: capture then read back in register mode
        set_ctrl(1'b0, 1'b1, 1'b1, 1'b1, 1'b0, 1'b0);
        ext_c2_byte = 8'h9A; ext_g1_byte = 8'h4C;
        run_frame();
        check8("R7", "c2 capture sent", c2_out, 8'h9A);
        check8("R9", "g1 capture sent", g1_out, 8'h4C);
        set_ctrl(1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0);
        ext_c2_byte = 8'h00; ext_g1_byte = 8'h00;
        run_frame();
        check8("R7", "c2 captured stored", c2_out, 8'h9A);
        check8("R9", "g1 captured stored", g1_out, 8'h4C);

        // R12: write on the load edge while capturing
        set_ctrl(1'b0, 1'b1, 1'b0, 1'b1, 1'b0, 1'b0);
        ext_c2_byte = 8'hE1;
        @(negedge clk);
        frame_stb = 1'b1;
        @(negedge clk);
        frame_stb = 1'b0;
        wr_en = 1'b1; wr_addr = 2'd1; wr_data = 8'h0F;
        @(negedge clk);
        wr_en = 1'b0;
        set_ctrl(1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0);
        run_frame();
        check8("R12", "capture beats write", c2_out, 8'hE1);

        // R13: spare address ignored
        write_reg(2'd3, 8'hFF);
        b3_calc = 8'h10;
        run_frame();
        check8("R13", "b3 after spare write", b3_out, 8'h91);
        check8("R13", "c2 after spare write", c2_out, 8'hE1);
        check8("R13", "g1 after spare write", g1_out, 8'h4C);

        // R4: errors persist, then stop after mask cleared
        b3_calc = 8'h22;
        run_frame();
        check8("R4", "errors persist", b3_out, 8'hA3);
        write_reg(2'd0, 8'h00);
        run_frame();
        check8("R4", "mask cleared", b3_out, 8'h22);

        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule